// File: doc/BRIEF.md
# Flash write sequencer

This block sits on the host side of an asynchronous 16-bit NOR flash bus. It accepts one request at a time: program a word, erase a sector, erase a block, or erase the whole chip. It then runs the full unlock and command write sequence on the bus, with write-enable pulse widths counted in system clocks. After the last write it polls the target location, comparing the toggling status bit across back-to-back reads, and it ends the operation with either a completion pulse or a timeout pulse.

The bus data lines are modelled as three separate signals: an output value, an output enable, and an input value. An I/O pad outside this block joins them. All bus timing comes from clock-count parameters, so the same RTL can serve any system clock. A power-up hold keeps the sequencer from accepting work until the flash supply has settled.

Top module: `nor_wr_seq`

## Requirements
- R1: A program request (`req_kind` = 0) produces exactly four bus writes, in this order: 5555h/00AAh, 2AAAh/0055h, 5555h/00A0h, and then the request address with the request data.
- R2: An erase request produces exactly six bus writes: 5555h/00AAh, 2AAAh/0055h, 5555h/0080h, 5555h/00AAh, 2AAAh/0055h, then a final write chosen by kind. For a sector erase (`req_kind` = 1), the final write is the request address with bits 10:0 cleared, and data 0030h. For a block erase (`req_kind` = 2), it is the request address with bits 14:0 cleared, and data 0050h. For a chip erase (`req_kind` = 3), it is 5555h/0010h.
- R3: Each write-enable low phase lasts at least `WE_LOW_CYC` clocks. Between pulses, write-enable stays high for at least `WE_HIGH_CYC` clocks. While write-enable is low, chip-enable is low, the data lines are driven, and the address and data are stable.
- R4: During a status read, the data lines are not driven. Output-enable stays low for exactly `OE_ACC_CYC` clocks. Write-enable and output-enable are never low at the same time.
- R5: After the last command write, every status read uses the request address as given.
- R6: Completion requires DQ6 (bit 6) to be the same across `CONFIRM_READS`+2 consecutive reads, which means `CONFIRM_READS`+1 matching pairs in a row. Any toggle restarts the count. A single matching pair followed by a toggle does not complete the operation. `op_done` is issued right after the read that makes the run complete.
- R7: If polling has not completed within `TIMEOUT_CYC` clocks, `op_timeout` pulses after the read in progress ends. `op_done` is not raised, and the sequencer becomes ready again.
- R8: For `PWRUP_CYC` clocks after reset, `req_ready` stays low, requests have no effect, and no write is issued.
- R9: `req_ready` falls in the cycle after a request is accepted. Requests made while the sequencer is busy are ignored. `op_done` and `op_timeout` are single-cycle pulses, are never high together, and `req_ready` is high when either one is raised.
- R10: While reset is held, chip-enable, output-enable and write-enable are high, the data lines are not driven, and `req_ready`, `op_done` and `op_timeout` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request strobe, taken when `req_ready` is high |
| req_kind | input | 2 | 0 program, 1 sector erase, 2 block erase, 3 chip erase |
| req_addr | input | 20 | Target word address |
| req_wdata | input | 16 | Word to program |
| req_ready | output | 1 | Idle and able to accept a request |
| op_done | output | 1 | Pulse: operation completed |
| op_timeout | output | 1 | Pulse: polling exceeded its limit |
| fl_addr | output | 20 | Flash address lines |
| fl_dq_o | output | 16 | Data value driven toward the flash |
| fl_dq_oe | output | 1 | Drive enable for the data lines |
| fl_dq_i | input | 16 | Data value read from the flash |
| fl_ce_n | output | 1 | Chip enable, active low |
| fl_oe_n | output | 1 | Output enable, active low |
| fl_we_n | output | 1 | Write enable, active low |

## Verification
Each request kind is tried with both directed and random addresses. The directed addresses have low bits set, which separates correct sector and block alignment from passing the address straight through or using the wrong mask width. A flash model drives DQ6 with a busy length chosen per request. A plain toggle-then-settle pattern fixes the exact number of reads, so both a missing confirmation read and an extra one are caught. A pattern with one false early match tells the two-read recheck apart from a single compare. A busy status that never settles exercises the timeout path. Holding the request strobe through power-up and through busy periods shows that it is ignored at those times.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

  parameter int AW = 20;
  parameter int DW = 16;

  localparam int SECT_LSB = 11;
  localparam int BLK_LSB  = 15;

  localparam logic [AW-1:0] UNLK_A    = AW'(16'h5555);
  localparam logic [AW-1:0] UNLK_B    = AW'(16'h2AAA);
  localparam logic [DW-1:0] KEY_A     = DW'(8'hAA);
  localparam logic [DW-1:0] KEY_B     = DW'(8'h55);
  localparam logic [DW-1:0] OPC_PROG  = DW'(8'hA0);
  localparam logic [DW-1:0] OPC_ERASE = DW'(8'h80);
  localparam logic [DW-1:0] OPC_SECT  = DW'(8'h30);
  localparam logic [DW-1:0] OPC_BLK   = DW'(8'h50);
  localparam logic [DW-1:0] OPC_CHIP  = DW'(8'h10);

  typedef enum logic [1:0] {
    K_PROG = 2'd0,
    K_SECT = 2'd1,
    K_BLK  = 2'd2,
    K_CHIP = 2'd3
  } op_kind_e;

  typedef enum logic [1:0] {
    S_WAIT,
    S_IDLE,
    S_CMD,
    S_POLL
  } seq_st_e;

  typedef enum logic [2:0] {
    B_IDLE,
    B_SETUP,
    B_WLOW,
    B_WHIGH,
    B_RLOW,
    B_RGAP
  } bus_st_e;

  typedef struct packed {
    logic [AW-1:0] a;
    logic [DW-1:0] d;
  } bus_word_t;

  // number of write cycles in the sequence for a kind
  function automatic logic [2:0] n_writes(op_kind_e k);
    return (k == K_PROG) ? 3'd4 : 3'd6;
  endfunction

  // address placed on the final erase write
  function automatic logic [AW-1:0] erase_target(op_kind_e k, logic [AW-1:0] a);
    logic [AW-1:0] m;
    case (k)
      K_SECT:  m = ~AW'((1 << SECT_LSB) - 1);
      K_BLK:   m = ~AW'((1 << BLK_LSB) - 1);
      default: m = '1;
    endcase
    return a & m;
  endfunction

  // bus word for write number idx of a request
  function automatic bus_word_t cmd_word(op_kind_e k, logic [2:0] idx,
                                         logic [AW-1:0] a, logic [DW-1:0] d);
    bus_word_t w;
    w.a = UNLK_A;
    w.d = KEY_A;
    case (idx)
      3'd0: ;
      3'd1: begin w.a = UNLK_B; w.d = KEY_B; end
      3'd2: w.d = (k == K_PROG) ? OPC_PROG : OPC_ERASE;
      3'd3: if (k == K_PROG) begin w.a = a; w.d = d; end
      3'd4: begin w.a = UNLK_B; w.d = KEY_B; end
      default: begin
        case (k)
          K_SECT:  begin w.a = erase_target(k, a); w.d = OPC_SECT; end
          K_BLK:   begin w.a = erase_target(k, a); w.d = OPC_BLK;  end
          default: begin w.a = UNLK_A;             w.d = OPC_CHIP; end
        endcase
      end
    endcase
    return w;
  endfunction

endpackage

// File: rtl/nor_pwrup_wait.sv
module nor_pwrup_wait #(
  parameter int PWRUP_CYC = 12500
) (
  input  logic clk,
  input  logic rst_n,
  output logic pwr_ok
);
  localparam int CW = $clog2(PWRUP_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(PWRUP_CYC);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (cnt != LIMIT)   cnt <= cnt + 1'b1;
  end

  assign pwr_ok = (cnt == LIMIT);
endmodule

// File: rtl/nor_bus_engine.sv
module nor_bus_engine
  import nor_seq_pkg::*;
#(
  parameter int WE_LOW_CYC  = 5,
  parameter int WE_HIGH_CYC = 4,
  parameter int OE_ACC_CYC  = 9,
  parameter int RD_GAP_CYC  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          is_rd,
  input  logic [AW-1:0] addr_in,
  input  logic [DW-1:0] wdata_in,
  output logic          done,
  output logic          rd_vld,
  output logic [DW-1:0] rd_data,
  output logic [AW-1:0] fl_addr,
  output logic [DW-1:0] fl_dq_o,
  output logic          fl_dq_oe,
  input  logic [DW-1:0] fl_dq_i,
  output logic          fl_ce_n,
  output logic          fl_oe_n,
  output logic          fl_we_n
);
  localparam int MAXP = (WE_LOW_CYC > WE_HIGH_CYC ? WE_LOW_CYC : WE_HIGH_CYC) >
                        (OE_ACC_CYC > RD_GAP_CYC ? OE_ACC_CYC : RD_GAP_CYC) ?
                        (WE_LOW_CYC > WE_HIGH_CYC ? WE_LOW_CYC : WE_HIGH_CYC) :
                        (OE_ACC_CYC > RD_GAP_CYC ? OE_ACC_CYC : RD_GAP_CYC);
  localparam int CW = $clog2(MAXP + 1);
  localparam logic [CW-1:0] WL_LAST = CW'(WE_LOW_CYC - 1);
  localparam logic [CW-1:0] WH_LAST = CW'(WE_HIGH_CYC - 1);
  localparam logic [CW-1:0] RL_LAST = CW'(OE_ACC_CYC - 1);
  localparam logic [CW-1:0] RG_LAST = CW'(RD_GAP_CYC - 1);

  bus_st_e       st;
  logic [CW-1:0] cnt;
  logic [AW-1:0] a_q;
  logic [DW-1:0] d_q;
  logic          phase_end;

  // last clock of the current timed phase
  always_comb begin
    case (st)
      B_WLOW:  phase_end = (cnt == WL_LAST);
      B_WHIGH: phase_end = (cnt == WH_LAST);
      B_RLOW:  phase_end = (cnt == RL_LAST);
      B_RGAP:  phase_end = (cnt == RG_LAST);
      default: phase_end = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= B_IDLE;
      cnt     <= '0;
      a_q     <= '0;
      d_q     <= '0;
      done    <= 1'b0;
      rd_vld  <= 1'b0;
      rd_data <= '0;
    end else begin
      done   <= 1'b0;
      rd_vld <= 1'b0;
      cnt    <= phase_end ? '0 : cnt + 1'b1;
      case (st)
        B_IDLE: begin
          cnt <= '0;
          if (start) begin
            a_q <= addr_in;
            d_q <= wdata_in;
            st  <= is_rd ? B_RLOW : B_SETUP;
          end
        end
        B_SETUP: st <= B_WLOW;
        B_WLOW:  if (phase_end) st <= B_WHIGH;
        B_WHIGH: if (phase_end) begin st <= B_IDLE; done <= 1'b1; end
        B_RLOW: begin
          if (phase_end) begin
            rd_data <= fl_dq_i;
            rd_vld  <= 1'b1;
            st      <= B_RGAP;
          end
        end
        B_RGAP:  if (phase_end) begin st <= B_IDLE; done <= 1'b1; end
        default: st <= B_IDLE;
      endcase
    end
  end

  // pin decode from the phase register
  always_comb begin
    fl_addr  = a_q;
    fl_dq_o  = d_q;
    fl_ce_n  = 1'b1;
    fl_oe_n  = 1'b1;
    fl_we_n  = 1'b1;
    fl_dq_oe = 1'b0;
    case (st)
      B_SETUP: begin fl_ce_n = 1'b0; fl_dq_oe = 1'b1; end
      B_WLOW:  begin fl_ce_n = 1'b0; fl_we_n = 1'b0; fl_dq_oe = 1'b1; end
      B_WHIGH: fl_dq_oe = 1'b1;
      B_RLOW:  begin fl_ce_n = 1'b0; fl_oe_n = 1'b0; end
      default: ;
    endcase
  end
endmodule

// File: rtl/nor_toggle_judge.sv
module nor_toggle_judge #(
  parameter int CONFIRM_READS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic sample_vld,
  input  logic dq6,
  output logic settled
);
  localparam int NEED = CONFIRM_READS + 1;
  localparam int RW   = $clog2(NEED + 1);
  localparam logic [RW-1:0] NEED_V = RW'(NEED);

  logic          have_prev;
  logic          prev;
  logic [RW-1:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_prev <= 1'b0;
      prev      <= 1'b0;
      run       <= '0;
    end else if (clear) begin
      have_prev <= 1'b0;
      run       <= '0;
    end else if (sample_vld) begin
      prev      <= dq6;
      have_prev <= 1'b1;
      if (have_prev && (dq6 == prev)) begin
        if (run != NEED_V) run <= run + 1'b1;
      end else begin
        run <= '0;
      end
    end
  end

  assign settled = (run == NEED_V);
endmodule

// File: rtl/nor_poll_timer.sv
module nor_poll_timer #(
  parameter int TIMEOUT_CYC = 12500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  output logic expired
);
  localparam int TW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [TW-1:0] LIMIT = TW'(TIMEOUT_CYC);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        cnt <= '0;
    else if (clear)                    cnt <= '0;
    else if (run && (cnt != LIMIT))    cnt <= cnt + 1'b1;
  end

  assign expired = (cnt == LIMIT);
endmodule

// File: rtl/nor_wr_seq.sv
module nor_wr_seq
  import nor_seq_pkg::*;
#(
  parameter int PWRUP_CYC     = 12500,
  parameter int WE_LOW_CYC    = 5,
  parameter int WE_HIGH_CYC   = 4,
  parameter int OE_ACC_CYC    = 9,
  parameter int RD_GAP_CYC    = 2,
  parameter int CONFIRM_READS = 2,
  parameter int TIMEOUT_CYC   = 12500000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [1:0]    req_kind,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          req_ready,
  output logic          op_done,
  output logic          op_timeout,
  output logic [AW-1:0] fl_addr,
  output logic [DW-1:0] fl_dq_o,
  output logic          fl_dq_oe,
  input  logic [DW-1:0] fl_dq_i,
  output logic          fl_ce_n,
  output logic          fl_oe_n,
  output logic          fl_we_n
);
  seq_st_e       st;
  op_kind_e      kind_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic [2:0]    idx;
  logic          bus_start, bus_rd;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;
  logic          bus_done, rd_vld;
  logic [DW-1:0] rd_data;
  logic          pwr_ok, settled, expired, poll_clr;
  bus_word_t     first_w, next_w;

  // named internal events
  wire cmd_step_done  = (st == S_CMD)  && bus_done;
  wire last_cmd       = (idx == n_writes(kind_q) - 3'd1);
  wire poll_read_done = (st == S_POLL) && bus_done;
  wire accept         = (st == S_IDLE) && req_valid;

  always_comb begin
    first_w = cmd_word(op_kind_e'(req_kind), 3'd0, req_addr, req_wdata);
    next_w  = cmd_word(kind_q, idx + 3'd1, addr_q, data_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_WAIT;
      kind_q     <= K_PROG;
      addr_q     <= '0;
      data_q     <= '0;
      idx        <= '0;
      bus_start  <= 1'b0;
      bus_rd     <= 1'b0;
      bus_addr   <= '0;
      bus_wdata  <= '0;
      op_done    <= 1'b0;
      op_timeout <= 1'b0;
      poll_clr   <= 1'b0;
    end else begin
      bus_start  <= 1'b0;
      op_done    <= 1'b0;
      op_timeout <= 1'b0;
      poll_clr   <= 1'b0;
      case (st)
        S_WAIT: if (pwr_ok) st <= S_IDLE;
        S_IDLE: begin
          if (accept) begin
            kind_q    <= op_kind_e'(req_kind);
            addr_q    <= req_addr;
            data_q    <= req_wdata;
            idx       <= '0;
            bus_addr  <= first_w.a;
            bus_wdata <= first_w.d;
            bus_rd    <= 1'b0;
            bus_start <= 1'b1;
            st        <= S_CMD;
          end
        end
        S_CMD: begin
          if (cmd_step_done) begin
            bus_start <= 1'b1;
            if (last_cmd) begin
              bus_addr <= addr_q;
              bus_rd   <= 1'b1;
              poll_clr <= 1'b1;
              st       <= S_POLL;
            end else begin
              idx       <= idx + 3'd1;
              bus_addr  <= next_w.a;
              bus_wdata <= next_w.d;
            end
          end
        end
        S_POLL: begin
          if (poll_read_done) begin
            if (settled) begin
              op_done <= 1'b1;
              st      <= S_IDLE;
            end else if (expired) begin
              op_timeout <= 1'b1;
              st         <= S_IDLE;
            end else begin
              bus_start <= 1'b1;
            end
          end
        end
        default: st <= S_WAIT;
      endcase
    end
  end

  assign req_ready = (st == S_IDLE);

  nor_pwrup_wait #(.PWRUP_CYC(PWRUP_CYC)) pwr_i (
    .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok)
  );

  nor_bus_engine #(
    .WE_LOW_CYC(WE_LOW_CYC), .WE_HIGH_CYC(WE_HIGH_CYC),
    .OE_ACC_CYC(OE_ACC_CYC), .RD_GAP_CYC(RD_GAP_CYC)
  ) bus_i (
    .clk(clk), .rst_n(rst_n), .start(bus_start), .is_rd(bus_rd),
    .addr_in(bus_addr), .wdata_in(bus_wdata), .done(bus_done),
    .rd_vld(rd_vld), .rd_data(rd_data),
    .fl_addr(fl_addr), .fl_dq_o(fl_dq_o), .fl_dq_oe(fl_dq_oe), .fl_dq_i(fl_dq_i),
    .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n)
  );

  nor_toggle_judge #(.CONFIRM_READS(CONFIRM_READS)) judge_i (
    .clk(clk), .rst_n(rst_n), .clear(poll_clr),
    .sample_vld(rd_vld), .dq6(rd_data[6]), .settled(settled)
  );

  nor_poll_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) tmr_i (
    .clk(clk), .rst_n(rst_n), .clear(poll_clr),
    .run(st == S_POLL), .expired(expired)
  );
endmodule

// File: rtl/nor_wr_seq_chk.sv
module nor_wr_seq_chk #(
  parameter int PWRUP_CYC   = 12500,
  parameter int WE_LOW_CYC  = 5,
  parameter int WE_HIGH_CYC = 4,
  parameter int OE_ACC_CYC  = 9
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        op_done,
  input logic        op_timeout,
  input logic [19:0] fl_addr,
  input logic [15:0] fl_dq_o,
  input logic        fl_dq_oe,
  input logic        fl_ce_n,
  input logic        fl_oe_n,
  input logic        fl_we_n
);
  localparam int PW = $clog2(PWRUP_CYC + 1);
  localparam logic [PW-1:0] PW_LIM = PW'(PWRUP_CYC);
  localparam logic [7:0] WL_V = 8'(WE_LOW_CYC);
  localparam logic [7:0] WH_V = 8'(WE_HIGH_CYC);
  localparam logic [7:0] OE_V = 8'(OE_ACC_CYC);

  logic [PW-1:0] up_cnt;
  logic [7:0]    lo_cnt, hi_cnt, oe_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_cnt <= '0;
      lo_cnt <= '0;
      hi_cnt <= 8'hFF;
      oe_cnt <= '0;
    end else begin
      if (up_cnt != PW_LIM) up_cnt <= up_cnt + 1'b1;
      lo_cnt <= fl_we_n ? 8'd0 : ((lo_cnt == 8'hFF) ? lo_cnt : lo_cnt + 8'd1);
      hi_cnt <= !fl_we_n ? 8'd0 : ((hi_cnt == 8'hFF) ? hi_cnt : hi_cnt + 8'd1);
      oe_cnt <= fl_oe_n ? 8'd0 : ((oe_cnt == 8'hFF) ? oe_cnt : oe_cnt + 8'd1);
    end
  end

  // R3
  we_low_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fl_we_n) |-> (lo_cnt >= WL_V));
  // R3
  we_high_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fl_we_n) |-> (hi_cnt >= WH_V));
  // R3
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fl_we_n && $past(!fl_we_n)) |-> ($stable(fl_addr) && $stable(fl_dq_o)));
  // R3
  wr_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_we_n |-> (!fl_ce_n && fl_dq_oe));
  // R4
  rd_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_oe_n |-> (!fl_dq_oe && fl_we_n));
  // R4
  oe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fl_oe_n) |-> (oe_cnt == OE_V));
  // R8
  pwrup_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fl_we_n || req_ready) |-> (up_cnt == PW_LIM));
  // R9
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(op_done && op_timeout));
  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_done || op_timeout) |=> !(op_done || op_timeout));
  // R9
  accept_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && req_valid) |=> !req_ready);
  // R9
  end_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_done || op_timeout) |-> req_ready);
endmodule

bind nor_wr_seq nor_wr_seq_chk #(
  .PWRUP_CYC(PWRUP_CYC), .WE_LOW_CYC(WE_LOW_CYC),
  .WE_HIGH_CYC(WE_HIGH_CYC), .OE_ACC_CYC(OE_ACC_CYC)
) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .op_done(op_done), .op_timeout(op_timeout), .fl_addr(fl_addr),
  .fl_dq_o(fl_dq_o), .fl_dq_oe(fl_dq_oe), .fl_ce_n(fl_ce_n),
  .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n)
);

// File: tb/nor_wr_seq_tb_top.sv
module nor_wr_seq_tb_top;
  localparam int PWRUP   = 200;
  localparam int WE_LOW  = 5;
  localparam int WE_HIGH = 4;
  localparam int OE_ACC  = 9;
  localparam int RD_GAP  = 2;
  localparam int CONFIRM = 2;
  localparam int TMO     = 3000;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_kind = 2'd0;
  logic [19:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        req_ready, op_done, op_timeout;
  logic [19:0] fl_addr;
  logic [15:0] fl_dq_o;
  logic        fl_dq_oe;
  logic [15:0] fl_dq_i;
  logic        fl_ce_n, fl_oe_n, fl_we_n;

  int n_chk = 0;
  int n_bad = 0;

  nor_wr_seq #(
    .PWRUP_CYC(PWRUP), .WE_LOW_CYC(WE_LOW), .WE_HIGH_CYC(WE_HIGH),
    .OE_ACC_CYC(OE_ACC), .RD_GAP_CYC(RD_GAP), .CONFIRM_READS(CONFIRM),
    .TIMEOUT_CYC(TMO)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .op_done(op_done), .op_timeout(op_timeout), .fl_addr(fl_addr),
    .fl_dq_o(fl_dq_o), .fl_dq_oe(fl_dq_oe), .fl_dq_i(fl_dq_i),
    .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n)
  );

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ---------------- flash model and bus monitor ----------------
  int          wr_n, rd_n, wr_viol, rd_viol, rd_bad_addr;
  logic [19:0] wr_a [0:15];
  logic [15:0] wr_d [0:15];
  logic [19:0] fall_a, poll_a;
  logic [15:0] fall_d;
  int          lo_c, hi_c, oe_c;
  bit          prev_we, prev_oe;
  int          mdl_busy = 1;
  int          mdl_glitch = -1;

  function automatic bit dq6_at(int k);
    int j;
    j = (mdl_glitch >= 0 && k >= mdl_glitch) ? k - 1 : k;
    if (j < 0) j = 0;
    if (j < mdl_busy) return (j % 2) != 0;
    return ((mdl_busy - 1) % 2) != 0;
  endfunction

  // reads until CONFIRM+1 equal neighbouring pairs in a row
  function automatic int exp_reads();
    int run = 0;
    for (int k = 1; k < 5000; k++) begin
      if (dq6_at(k) == dq6_at(k - 1)) run++;
      else run = 0;
      if (run == CONFIRM + 1) return k + 1;
    end
    return -1;
  endfunction

  always @(negedge clk) begin
    if (!rst_n) begin
      wr_n = 0; rd_n = 0; wr_viol = 0; rd_viol = 0; rd_bad_addr = 0;
      lo_c = 0; hi_c = 1000; oe_c = 0; prev_we = 1'b1; prev_oe = 1'b1;
      fl_dq_i = 16'h0000;
    end else begin
      if (prev_we && !fl_we_n) begin
        fall_a = fl_addr; fall_d = fl_dq_o;
        if (hi_c < WE_HIGH) wr_viol++;
        lo_c = 1;
      end else if (!fl_we_n) begin
        lo_c++;
        if (fl_addr != fall_a || fl_dq_o != fall_d) wr_viol++;
      end
      if (!fl_we_n && (fl_ce_n || !fl_dq_oe || !fl_oe_n)) wr_viol++;
      if (!prev_we && fl_we_n) begin
        if (lo_c < WE_LOW) wr_viol++;
        if (wr_n < 16) begin wr_a[wr_n] = fall_a; wr_d[wr_n] = fl_dq_o; end
        wr_n++;
        hi_c = 1;
      end else if (fl_we_n) begin
        hi_c++;
      end
      if (prev_oe && !fl_oe_n) begin
        if (fl_addr != poll_a) rd_bad_addr++;
        fl_dq_i = {8'h00, 1'b0, dq6_at(rd_n), 6'h15};
        rd_n++;
        oe_c = 1;
      end else if (!fl_oe_n) begin
        oe_c++;
      end
      if (!fl_oe_n && fl_dq_oe) rd_viol++;
      if (!prev_oe && fl_oe_n && oe_c != OE_ACC) rd_viol++;
      prev_we = fl_we_n;
      prev_oe = fl_oe_n;
    end
  end

  // expected write i of a request, stated from the requirements
  task automatic exp_word(int kind, int i, logic [19:0] a_in, logic [15:0] d_in,
                          output logic [19:0] a, output logic [15:0] d);
    case (i)
      0: begin a = 20'h05555; d = 16'h00AA; end
      1: begin a = 20'h02AAA; d = 16'h0055; end
      2: begin a = 20'h05555; d = (kind == 0) ? 16'h00A0 : 16'h0080; end
      3: if (kind == 0) begin a = a_in; d = d_in; end
         else begin a = 20'h05555; d = 16'h00AA; end
      4: begin a = 20'h02AAA; d = 16'h0055; end
      default: begin
        if (kind == 1)      begin a = {a_in[19:11], 11'd0}; d = 16'h0030; end
        else if (kind == 2) begin a = {a_in[19:15], 15'd0}; d = 16'h0050; end
        else                begin a = 20'h05555; d = 16'h0010; end
      end
    endcase
  endtask

  task automatic do_op(int kind, logic [19:0] addr, logic [15:0] data,
                       int busy, int glitch, bit expect_to);
    int  waitc, n_exp, n_rd;
    bit  got_done, got_to;
    string tag;
    logic [19:0] ea;
    logic [15:0] ed;
    tag = (kind == 0) ? "R1" : "R2";
    waitc = 0;
    while (!req_ready && waitc < 50000) begin @(negedge clk); waitc++; end
    mdl_busy = busy; mdl_glitch = glitch; poll_a = addr;
    wr_n = 0; rd_n = 0; wr_viol = 0; rd_viol = 0; rd_bad_addr = 0;
    n_rd = exp_reads();
    req_kind = 2'(kind); req_addr = addr; req_wdata = data; req_valid = 1'b1;
    @(negedge clk);
    chk(!req_ready, "R9", "ready after accept", longint'(req_ready), 0);
    // busy-time requests with other fields must be ignored
    req_kind = 2'(kind) ^ 2'b11; req_addr = ~addr; req_wdata = ~data;
    repeat (15) @(negedge clk);
    req_valid = 1'b0;
    got_done = 1'b0; got_to = 1'b0; waitc = 0;
    while (!got_done && !got_to && waitc < 20000) begin
      @(negedge clk); waitc++;
      if (op_done) got_done = 1'b1;
      if (op_timeout) got_to = 1'b1;
    end
    chk(req_ready, "R9", "ready with end pulse", longint'(req_ready), 1);
    @(negedge clk);
    chk(!op_done && !op_timeout, "R9", "end pulse length", longint'({op_done, op_timeout}), 0);
    n_exp = (kind == 0) ? 4 : 6;
    chk(wr_n == n_exp, tag, "write count", wr_n, n_exp);
    for (int i = 0; i < n_exp; i++) begin
      exp_word(kind, i, addr, data, ea, ed);
      chk(wr_a[i] == ea && wr_d[i] == ed, tag, $sformatf("write %0d addr/data", i),
          longint'({wr_a[i], wr_d[i]}), longint'({ea, ed}));
    end
    chk(wr_viol == 0, "R3", "write timing violations", wr_viol, 0);
    chk(rd_viol == 0, "R4", "read drive/width violations", rd_viol, 0);
    chk(rd_bad_addr == 0, "R5", "poll address mismatches", rd_bad_addr, 0);
    if (expect_to) begin
      chk(got_to && !got_done, "R7", "timeout reported", longint'({got_to, got_done}), 2);
      chk(req_ready, "R7", "ready after timeout", longint'(req_ready), 1);
    end else begin
      chk(got_done && !got_to, "R6", "done reported", longint'({got_done, got_to}), 2);
      chk(rd_n == n_rd, "R6", "status reads", rd_n, n_rd);
    end
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual expired expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  // ---------------- main sequence ----------------
  initial begin
    int seed_v, ready_at;
    seed_v = $urandom(32'd20231);
    req_valid = 1'b1;          // held through reset and power-up
    repeat (3) @(negedge clk);
    chk(fl_ce_n && fl_oe_n && fl_we_n, "R10", "strobes in reset",
        longint'({fl_ce_n, fl_oe_n, fl_we_n}), 7);
    chk(!fl_dq_oe, "R10", "dq drive in reset", longint'(fl_dq_oe), 0);
    chk(!req_ready && !op_done && !op_timeout, "R10", "status in reset",
        longint'({req_ready, op_done, op_timeout}), 0);
    rst_n = 1'b1;
    repeat (PWRUP - 10) @(negedge clk);
    chk(!req_ready, "R8", "ready during power-up", longint'(req_ready), 0);
    chk(wr_n == 0, "R8", "writes during power-up", wr_n, 0);
    req_valid = 1'b0;
    ready_at = PWRUP - 10;
    while (!req_ready && ready_at < PWRUP + 50) begin @(negedge clk); ready_at++; end
    chk(ready_at >= PWRUP && ready_at <= PWRUP + 4, "R8", "power-up release cycle",
        ready_at, PWRUP);
    chk(wr_n == 0, "R8", "writes before first request", wr_n, 0);

    // directed corners
    do_op(0, 20'h3C0F1, 16'hBEEF, 4, -1, 1'b0);
    do_op(1, 20'hABCDE, 16'h0000, 5, -1, 1'b0);
    do_op(2, 20'h5FFFF, 16'h0000, 3, -1, 1'b0);
    do_op(3, 20'h12345, 16'h0000, 7, -1, 1'b0);
    do_op(0, 20'hFFFFF, 16'hFFFF, 1, -1, 1'b0);
    do_op(1, 20'h007FF, 16'h0000, 6, 3, 1'b0);   // false early match (R6)
    do_op(3, 20'h00000, 16'h0000, 100000, -1, 1'b1);  // never settles (R7)

    // constrained random
    for (int n = 0; n < 10; n++) begin
      int k, b, g;
      k = int'($urandom_range(3, 0));
      b = int'($urandom_range(8, 1));
      g = -1;
      if (b >= 3 && $urandom_range(1, 0) == 1) g = int'($urandom_range(b - 1, 1));
      do_op(k, 20'($urandom), 16'($urandom), b, g, 1'b0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule